// File: doc/BRIEF.md
# Differential Clock Output Stop Controller

This block gates a bank of differential clock outputs so that clocks can be stopped and restarted without glitches. Each output pair has a true leg and a complement leg. Each leg is modelled as a value and an output enable. The true leg follows the buffered clock `clk` and the complement leg follows its inverse. The complement clock therefore rises on a falling edge of `clk` and falls on a rising edge of `clk`.

A polarity strap is captured once, after reset. It sets the active level of three kinds of control input: the asynchronous power-down input, the per-pair enables and the global clock-stop input. Power-down first passes through a synchronizer. It must then be seen on two successive complement rising edges before it takes effect. Every pair then parks on the next complement falling edge. A drive-mode input selects the parked state: either the true leg is held high with the complement leg released, or both legs are released.

After reset or power-down, a lock-wait counter stands in for PLL settling. It must expire before any pair runs. A per-pair enable or the clock-stop input parks and restarts pairs under the same edge and drive-mode rules, but without the lock wait.

Top module: `diffclk_stop_ctl`

## Requirements
- R1: The strap level is captured on the first `clk` rising edge after `rst_n` goes high. Later changes of `strap_pol` have no effect on the outputs.
- R2: With the strap captured at 0, `pd_pin` is asserted when low, while each `oe_pin` bit and `stop_pin` are asserted when high.
- R3: With the strap captured at 1, `pd_pin` is asserted when high, while each `oe_pin` bit and `stop_pin` are asserted when low.
- R4: Power-down is confirmed only if it is sampled asserted on two consecutive `clk` falling edges, after a one-flop synchronizing stage. If it is asserted across only one such edge, it is ignored.
- R5: Once power-down is confirmed, every pair parks on the next `clk` rising edge. If power-down is asserted just after a rising edge, `pc_oe` drops to all zeros at the third rising edge after that and not before.
- R6: With `park_tri`=0, a parked pair has `pt_val`=1, `pt_oe`=1 and `pc_oe`=0.
- R7: With `park_tri`=1, a parked pair has `pt_oe`=0 and `pc_oe`=0.
- R8: After power-down is released just after a rising edge, the pairs stay parked for LOCK_CYC+1 rising edges. They restart on rising edge LOCK_CYC+2, and they restart together.
- R9: An `oe_pin` bit change that is applied just after a rising edge parks or restarts only its own pair, on the next rising edge, with no lock wait.
- R10: An asserted clock-stop parks all pairs on the next rising edge. Releasing it restarts the enabled pairs with no lock wait.
- R11: No level on `pt_val` or `pc_val` lasts less than half a `clk` period across park and restart.
- R12: While `rst_n` is low, all pairs are parked. After release, the lock wait of R8 applies from the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Buffered clock; complement clock is its inverse |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pol | input | 1 | Control polarity strap, captured once |
| pd_pin | input | 1 | Asynchronous power-down request |
| oe_pin | input | NUM_OUT | Per-pair enable requests |
| stop_pin | input | 1 | Global clock-stop request |
| park_tri | input | 1 | Drive mode: 0 true-high park, 1 both legs released |
| pt_val | output | NUM_OUT | True leg values |
| pt_oe | output | NUM_OUT | True leg output enables |
| pc_val | output | NUM_OUT | Complement leg values |
| pc_oe | output | NUM_OUT | Complement leg output enables |

## Verification
The hardest case to reach is the boundary of the two-edge filter. A power-down pulse is placed so that it covers exactly one falling edge of `clk`, and in a second test exactly two. The bench drives it a fixed offset after a rising edge and releases it one or two cycles later, so the pulse sits on a known number of sampling edges. Restart timing is then pinned to the exact rising edge by sampling on both sides of it. A monitor timestamps every edge of the first pair's legs, so that any short pulse at the moment of park or restart is counted.

// File: rtl/diffclk_stop_ctl.sv
module diffclk_stop_ctl #(
  parameter int NUM_OUT  = 8,
  parameter int LOCK_CYC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_pol,
  input  logic               pd_pin,
  input  logic [NUM_OUT-1:0] oe_pin,
  input  logic               stop_pin,
  input  logic               park_tri,
  output logic [NUM_OUT-1:0] pt_val,
  output logic [NUM_OUT-1:0] pt_oe,
  output logic [NUM_OUT-1:0] pc_val,
  output logic [NUM_OUT-1:0] pc_oe
);
  localparam int CW = $clog2(LOCK_CYC + 1);

  logic               cap, strap_q;
  logic [CW-1:0]      cnt;
  logic               s_m, s_a, s_b;
  logic [NUM_OUT-1:0] en_q, run_q;
  logic               pd_act, stop_act, conf, locked;
  logic [NUM_OUT-1:0] oe_act;

  assign pd_act   = strap_q ? pd_pin : ~pd_pin;
  assign stop_act = strap_q ? ~stop_pin : stop_pin;
  assign oe_act   = strap_q ? ~oe_pin : oe_pin;
  assign conf     = s_a & s_b;
  assign locked   = (cnt == CW'(LOCK_CYC));

  // complement rising edge: synchronizer stage plus two-sample filter, enable sampling
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_m  <= 1'b0;
      s_a  <= 1'b0;
      s_b  <= 1'b0;
      en_q <= '0;
    end else begin
      s_m  <= pd_act;
      s_a  <= s_m;
      s_b  <= s_a;
      en_q <= oe_act & {NUM_OUT{~stop_act}};
    end
  end

  // complement falling edge: strap capture, lock wait, park/restart
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap     <= 1'b0;
      strap_q <= 1'b0;
      cnt     <= '0;
      run_q   <= '0;
    end else begin
      if (!cap) begin
        cap     <= 1'b1;
        strap_q <= strap_pol;
        cnt     <= '0;
      end else if (conf) begin
        cnt <= '0;
      end else if (!locked) begin
        cnt <= cnt + 1'b1;
      end
      run_q <= en_q & {NUM_OUT{~conf & locked}};
    end
  end

  assign pt_val = (run_q & {NUM_OUT{clk}}) | ~run_q;
  assign pc_val = run_q & {NUM_OUT{~clk}};
  assign pt_oe  = run_q | {NUM_OUT{~park_tri}};
  assign pc_oe  = run_q;
endmodule

// File: rtl/diffclk_stop_chk.sv
module diffclk_stop_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         park_tri,
  input logic         conf,
  input logic         locked,
  input logic         cap,
  input logic         strap_q,
  input logic [N-1:0] pt_val,
  input logic [N-1:0] pt_oe,
  input logic [N-1:0] pc_oe
);
  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> $stable(strap_q));

  // R5 and R8: no pair may be running in the cycle after confirmation or while unlocked
  p_park_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conf || !locked) |=> (pc_oe == '0));

  p_true_high_r6: assert property (@(negedge clk) disable iff (!rst_n)
    !park_tri |-> (((~pc_oe & ~pt_val) == '0) && ((~pc_oe & ~pt_oe) == '0)));

  p_both_off_r7: assert property (@(negedge clk) disable iff (!rst_n)
    park_tri |-> ((~pc_oe & pt_oe) == '0));
endmodule

bind diffclk_stop_ctl diffclk_stop_chk #(.N(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .park_tri(park_tri), .conf(conf), .locked(locked),
  .cap(cap), .strap_q(strap_q), .pt_val(pt_val), .pt_oe(pt_oe), .pc_oe(pc_oe)
);

// File: tb/test_diffclk_stop_ctl.sv
`timescale 1ns/1ps
module test_diffclk_stop_ctl;
  localparam int N = 8;
  localparam int LOCK = 16;
  // {oe[7:0], stop, park_tri}
  localparam logic [9:0] VEC [7] = '{
    {8'hFF, 1'b0, 1'b0}, {8'hA5, 1'b0, 1'b0}, {8'h5A, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b0}, {8'h0F, 1'b1, 1'b1}, {8'h80, 1'b0, 1'b1},
    {8'hFF, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic pd_pin = 1'b1, stop_pin = 1'b0, park_tri = 1'b0;
  logic [N-1:0] oe_pin = '1;
  wire  [N-1:0] pt_val, pt_oe, pc_val, pc_oe;
  int checks = 0, fails = 0, glitches = 0;
  bit mon_en = 1'b0, cur_s = 1'b0;
  time last_t = 0, last_c = 0;

  diffclk_stop_ctl #(.NUM_OUT(N), .LOCK_CYC(LOCK)) i_diffclk_stop_ctl (
    .clk(clk), .rst_n(rst_n), .strap_pol(strap), .pd_pin(pd_pin), .oe_pin(oe_pin),
    .stop_pin(stop_pin), .park_tri(park_tri), .pt_val(pt_val), .pt_oe(pt_oe),
    .pc_val(pc_val), .pc_oe(pc_oe));

  always #5 clk = ~clk;

  always @(pt_val[0]) begin
    if (mon_en && ($time - last_t) < 5) glitches++;
    last_t = $time;
  end
  always @(pc_val[0]) begin
    if (mon_en && ($time - last_c) < 5) glitches++;
    last_c = $time;
  end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input bit pd_l, input logic [N-1:0] oe_l, input bit stop_l, input bit tri_l);
    pd_pin   = cur_s ? pd_l : ~pd_l;
    oe_pin   = cur_s ? ~oe_l : oe_l;
    stop_pin = cur_s ? ~stop_l : stop_l;
    park_tri = tri_l;
  endtask

  task automatic edge_wait(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic reset_to(input bit s);
    mon_en = 1'b0;
    rst_n = 1'b0;
    cur_s = s;
    strap = s;
    drive(1'b0, '1, 1'b0, 1'b0);
    edge_wait(3);
    chk("R12 reset pc_oe", pc_oe, '0);
    chk("R12 reset pt_oe", pt_oe, '1);
    chk("R12 reset pt_val", pt_val, '1);
    rst_n = 1'b1;
    edge_wait(LOCK + 1);
    chk("R12 R8 before lock", pc_oe, '0);
    edge_wait(1);
    chk("R12 R8 after lock", pc_oe, '1);
    mon_en = 1'b1;
  endtask

  task automatic run_strap(input bit s);
    string tag;
    tag = s ? "R3" : "R2";
    reset_to(s);
    foreach (VEC[k]) begin
      drive(1'b0, VEC[k][9:2], VEC[k][1], VEC[k][0]);
      edge_wait(2);
      chk({tag, " R9 R10 pc_oe"}, pc_oe, VEC[k][1] ? '0 : VEC[k][9:2]);
      chk({tag, " R6 R7 pt_oe"}, pt_oe, (VEC[k][1] ? '0 : VEC[k][9:2]) | {N{~VEC[k][0]}});
    end
    // R9: single-pair change lands on the next rising edge
    drive(1'b0, 8'hFE, 1'b0, 1'b0);
    edge_wait(1);
    chk("R9 one edge", pc_oe, 8'hFE);
    drive(1'b0, '1, 1'b0, 1'b0);
    edge_wait(1);
    chk("R9 restart", pc_oe, '1);
    // R4: one-edge power-down ignored
    drive(1'b1, '1, 1'b0, 1'b0);
    edge_wait(1);
    drive(1'b0, '1, 1'b0, 1'b0);
    edge_wait(6);
    chk({tag, " R4 single edge ignored"}, pc_oe, '1);
    // R4: two-edge power-down confirmed
    drive(1'b1, '1, 1'b0, 1'b0);
    edge_wait(2);
    drive(1'b0, '1, 1'b0, 1'b0);
    edge_wait(1);
    chk({tag, " R4 two edges park"}, pc_oe, '0);
    edge_wait(LOCK + 6);
    chk("R4 resumed", pc_oe, '1);
    // R5 timing, R6/R7 park levels, R8 restart
    drive(1'b1, '1, 1'b0, 1'b0);
    edge_wait(2);
    chk({tag, " R5 not yet"}, pc_oe, '1);
    edge_wait(1);
    chk({tag, " R5 parked"}, pc_oe, '0);
    chk("R6 true high", pt_val, '1);
    chk("R6 true driven", pt_oe, '1);
    drive(1'b1, '1, 1'b0, 1'b1);
    #1;
    chk("R7 true released", pt_oe, '0);
    chk("R7 comp released", pc_oe, '0);
    drive(1'b0, '1, 1'b0, 1'b0);
    edge_wait(LOCK + 1);
    chk("R8 still parked", pc_oe, '0);
    edge_wait(1);
    chk("R8 restarted", pc_oe, '1);
  endtask

  initial begin
    run_strap(1'b0);
    run_strap(1'b1);
    // R1: strap change after capture has no effect
    strap = 1'b0;
    edge_wait(8);
    chk("R1 strap ignored", pc_oe, '1);
    chk("R1 strap ignored pt_oe", pt_oe, '1);
    chk("R11 short pulses", N'(glitches), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule